// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Divider

This block derives a low-rate clock enable from one of three parent tick streams, so that over time the enable fires M times for every N parent ticks. A single 32-bit configuration word, written through a one-cycle write strobe, selects the parent, turns the output on or off and sets the ratio. Inside, a phase accumulator adds M on each tick of the chosen parent. Whenever the running sum reaches N, N is taken off the sum and a one-cycle pulse goes out.

All three parents are presented as enable pulses on the single block clock. One of them is the external reference, and the other two come from two PLLs. To pass the external reference straight through, software programs M = 1 and N = 1 so that every tick produces a pulse. The usual programming sequence writes the ratio with the enable bit clear, then writes the same word again with the enable bit set. Settings that cannot be honoured (N = 0, or M greater than N) hold the output low and raise an error flag while the enable bit is set.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the configuration word is zero, `clk_en_o` is low and `cfg_err_o` is low.
- R2: With a legal ratio, a window of N×k ticks of the selected parent, counted from a cleared accumulator, yields exactly M×k pulses. Each pulse is one cycle high, in the cycle after the parent tick that caused it.
- R3: Bits [31:30] choose the parent: 00 and 10 select `tick_ext`, 01 selects `tick_pll_a`, 11 selects `tick_pll_b`. Ticks on unselected parents never produce a pulse.
- R4: Bit 29 is the output enable. While it is 0 no pulse is produced, and writing it to 0 clears the accumulator.
- R5: M sits in bits [17:13] and N in bits [12:0]. When M equals N, including the pass-through setting M = N = 1, every selected tick gives a pulse.
- R6: When bit 29 is 1 and either N = 0 or M > N, `cfg_err_o` is high and no pulse is produced. When bit 29 is 0, `cfg_err_o` is low whatever the fields hold.
- R7: A write that changes M or N clears the accumulator. With M = 1, the first pulse after such a write comes on exactly the N-th selected tick.
- R8: A write that leaves M, N and the enable unchanged keeps the accumulator, so the pulse phase carries on across the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| tick_ext | input | 1 | External reference tick |
| tick_pll_a | input | 1 | First PLL tick |
| tick_pll_b | input | 1 | Second PLL tick |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| cfg_err_o | output | 1 | Illegal ratio while enabled |

## Verification
The hardest condition to reach from the ports is a change of M or N at a moment when the accumulator holds a large leftover from the old ratio. If that leftover were kept, it would show up only as a pulse that comes too early, or as a run of pulses when the new N is smaller than the leftover. The stimulus creates this case on purpose. It stops the ticks part way through a window with M = 5 and N = 13, which leaves the accumulator at 10. It then rewrites the word to M = 1 and N = 4, and measures on which tick the first pulse arrives. Random windows with noise on the unselected parents then cover the rate relation across many ratios.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int MW = 5,
  parameter int NW = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        tick_ext,
  input  logic        tick_pll_a,
  input  logic        tick_pll_b,
  output logic        clk_en_o,
  output logic        cfg_err_o
);
  localparam int AW    = NW + 1;
  localparam int FLDW  = NW + MW;
  localparam int EN_B  = 29;

  logic [31:0]   cfg_q, cfg_nxt;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;
  logic [AW-1:0] m_x, n_x;
  logic          pulse_q;
  logic          par_tick;
  logic          run_q, run_nxt, fld_chg;

  function automatic logic illegal(input logic [31:0] c);
    logic [NW-1:0] n;
    logic [MW-1:0] m;
    n = c[NW-1:0];
    m = c[FLDW-1:NW];
    return (n == '0) || (AW'(m) > AW'(n));
  endfunction

  assign cfg_nxt  = cfg_we ? cfg_wdata : cfg_q;
  assign run_q    = cfg_q[EN_B] & ~illegal(cfg_q);
  assign run_nxt  = cfg_nxt[EN_B] & ~illegal(cfg_nxt);
  assign fld_chg  = cfg_we && (cfg_wdata[FLDW-1:0] != cfg_q[FLDW-1:0]);
  assign m_x      = AW'(cfg_q[FLDW-1:NW]);
  assign n_x      = AW'(cfg_q[NW-1:0]);
  assign sum      = acc_q + m_x;

  always_comb begin
    case (cfg_q[31:30])
      2'b01:   par_tick = tick_pll_a;
      2'b11:   par_tick = tick_pll_b;
      default: par_tick = tick_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      if (!run_nxt || fld_chg) begin
        acc_q   <= '0;
        pulse_q <= 1'b0;
      end else if (par_tick) begin
        if (sum >= n_x) begin
          acc_q   <= sum - n_x;
          pulse_q <= 1'b1;
        end else begin
          acc_q   <= sum;
          pulse_q <= 1'b0;
        end
      end else begin
        pulse_q <= 1'b0;
      end
    end
  end

  assign clk_en_o  = pulse_q;
  assign cfg_err_o = cfg_q[EN_B] & illegal(cfg_q);

  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> run_q); // R4
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !clk_en_o); // R6
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> $past(par_tick)); // R2
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (acc_q < n_x)); // R2
  AST_EQUAL_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cfg_we && par_tick && (m_x == n_x)) |=> clk_en_o); // R5
endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  tk = '0;
  logic        clk_en_o, cfg_err_o;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cur_line = 0;
  bit          finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frac_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick_ext(tk[0]), .tick_pll_a(tk[1]), .tick_pll_b(tk[2]),
    .clk_en_o(clk_en_o), .cfg_err_o(cfg_err_o));

  function automatic int line_of(input logic [1:0] src);
    case (src)
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pulses(input int m, input int k);
    return m * k;
  endfunction

  function automatic int exp_first(input int m, input int n);
    return (n + m - 1) / m;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [1:0] src, input bit en, input int m, input int n);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {src, 1'b0, 11'd0, m[4:0], n[12:0]};
    cfg_wdata[29] = en;
    cur_line = line_of(src);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_sel(input int nticks, output int pulses, output int first);
    int done = 0;
    logic [31:0] v;
    pulses = 0;
    first = 0;
    while (done < nticks) begin
      @(negedge clk);
      if (clk_en_o) begin
        pulses++;
        if (first == 0) first = done;
      end
      v = $urandom;
      tk = v[2:0];
      tk[cur_line] = v[3];
      if (v[3]) done++;
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (clk_en_o) begin
        pulses++;
        if (first == 0) first = done;
      end
      tk = '0;
    end
  endtask

  task automatic drive_raw(input logic [2:0] mask, input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_en_o) pulses++;
      tk = mask & 3'($urandom);
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (clk_en_o) pulses++;
      tk = '0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p, f;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 clk_en_o after reset", clk_en_o, 0);
    chk("R1 cfg_err_o after reset", cfg_err_o, 0);
    drive_raw(3'b001, 6, p);
    chk("R1 no pulse from reset config", p, 0);

    // R5 pass-through of the external source, two-step write
    wcfg(2'b00, 1'b0, 1, 1);
    wcfg(2'b00, 1'b1, 1, 1);
    run_sel(10, p, f);
    chk("R5 bypass M=N=1 pulses", p, 10);
    wcfg(2'b01, 1'b1, 7, 7);
    run_sel(5, p, f);
    chk("R5 M=N=7 pulses", p, 5);

    // R2 fractional ratio
    wcfg(2'b11, 1'b0, 3, 7);
    wcfg(2'b11, 1'b1, 3, 7);
    run_sel(14, p, f);
    chk("R2 M=3 N=7 k=2", p, exp_pulses(3, 2));

    // R3 unselected parents ignored, and 10 selects external
    wcfg(2'b01, 1'b1, 1, 1);
    drive_raw(3'b101, 20, p);
    chk("R3 unselected ticks ignored", p, 0);
    wcfg(2'b10, 1'b1, 1, 1);
    run_sel(6, p, f);
    chk("R3 select 10 routes external", p, 6);
    drive_raw(3'b110, 20, p);
    chk("R3 PLL ticks ignored on 10", p, 0);

    // R4 enable gating and clear
    wcfg(2'b00, 1'b0, 1, 1);
    drive_raw(3'b001, 12, p);
    chk("R4 disabled gives no pulse", p, 0);
    wcfg(2'b00, 1'b1, 1, 4);
    run_sel(3, p, f);
    chk("R4 3 of 4 ticks no pulse yet", p, 0);
    wcfg(2'b00, 1'b0, 1, 4);
    wcfg(2'b00, 1'b1, 1, 4);
    run_sel(4, p, f);
    chk("R4 disable cleared accumulator first pulse", f, 4);

    // R6 illegal settings
    wcfg(2'b00, 1'b1, 5, 3);
    @(negedge clk);
    chk("R6 err for M>N", cfg_err_o, 1);
    drive_raw(3'b111, 20, p);
    chk("R6 no pulse for M>N", p, 0);
    wcfg(2'b00, 1'b1, 0, 0);
    @(negedge clk);
    chk("R6 err for N=0", cfg_err_o, 1);
    drive_raw(3'b111, 10, p);
    chk("R6 no pulse for N=0", p, 0);
    wcfg(2'b00, 1'b0, 5, 3);
    @(negedge clk);
    chk("R6 err low when disabled", cfg_err_o, 0);

    // R7 field change clears a large residue
    wcfg(2'b01, 1'b1, 5, 13);
    run_sel(2, p, f);
    chk("R7 pre-change no pulse", p, 0);
    wcfg(2'b01, 1'b1, 1, 4);
    run_sel(8, p, f);
    chk("R7 first pulse after change", f, exp_first(1, 4));
    chk("R7 pulses after change", p, exp_pulses(1, 2));

    // R8 identical rewrite keeps phase
    wcfg(2'b11, 1'b1, 1, 4);
    run_sel(2, p, f);
    wcfg(2'b11, 1'b1, 1, 4);
    run_sel(2, p, f);
    chk("R8 phase kept across rewrite", f, 2);

    // R2 random ratios, random sources, noisy other parents
    for (int it = 0; it < 12; it++) begin
      int n, m, k;
      logic [1:0] src;
      n = 1 + int'($urandom % 40);
      m = int'($urandom % (n + 1));
      if (m > 31) m = 31;
      k = 1 + int'($urandom % 3);
      src = 2'($urandom);
      wcfg(src, 1'b0, m, n);
      wcfg(src, 1'b1, m, n);
      run_sel(n * k, p, f);
      chk($sformatf("R2 random M=%0d N=%0d k=%0d", m, n, k), p, exp_pulses(m, k));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule